// File: doc/BRIEF.md
# Masked-Field Two-Level Connection Address Lookup

This block turns the two routing fields of an incoming cell header into the byte address of a 32-bit per-connection table entry. The combined port-and-path field is reduced through a programmable path mask. Every header bit that sits under a set mask bit is packed into a dense path pointer, so a table only needs as many entries as the mask has set bits allow. The path pointer selects one word in the path-level table. That word is read once from memory, and its low 16 bits give the offset of a channel-level table.

The channel field is then compressed the same way through its own mask. The final address is the channel table base plus four times the offset plus four times the channel pointer.

An optional check flags a cell as misinserted when its channel field has a 1 in a position that the channel mask does not cover. In that case no memory read is made and the reported address is zero. Configuration is captured when a header is accepted, so software may reprogram it while a lookup is in progress.

Top module: `conn_addr_lookup`

## Requirements
- R1: Pointer packing takes the header bits whose mask bit is 1, walking from mask bit 0 upward, and places them in pointer bits 0, 1, 2 and so on. Pointer bits above the mask's set-bit count are 0. Example: mask 0x0237 with field 0x0011 gives pointer 0x09, and mask 0x0037 with field 0x0031 gives pointer 0x19.
- R2: The single read request carries the path table base plus 4 times the path pointer (for example base 0x0024_0000 with pointer 0x09 gives 0x0024_0024). The request stays asserted with an unchanged address until it is accepted.
- R3: A header is accepted only while `hdr_ready` is 1, which holds only when the block is idle. Each cell that is not misinserted issues exactly one read request.
- R4: The channel table offset is bits 15:0 of the returned word. Bits 31:16 have no effect on the result.
- R5: The result address is the channel base plus 4 times the offset plus 4 times the channel pointer, modulo 2^32. For example, 0x0084_0000 with offset 0x100 and pointer 0x19 gives 0x0084_0464.
- R6: When the check enable is 1 and the channel field has a 1 where the channel mask is 0, the cell is misinserted. The result then comes one cycle after acceptance with `res_misins`=1 and `res_addr`=0, and no read request is made.
- R7: When the check enable is 0, uncovered channel bits do not set `res_misins` and do not change the address.
- R8: `res_valid` is a single-cycle pulse. For a read lookup it rises two cycles after the cycle in which the response is returned.
- R9: The masks, bases, check enable and header fields are sampled at acceptance. Later changes to them do not affect the lookup in progress.
- R10: After reset, `hdr_ready`=1, `rd_req_valid`=0 and `res_valid`=0.
- R11: A response strobe that arrives while no read is outstanding is ignored. It produces no result and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_vp_mask | input | 16 | Path field index mask |
| cfg_vc_mask | input | 16 | Channel field index mask |
| cfg_vp_base | input | 32 | Path-level table base address |
| cfg_vc_base | input | 32 | Channel-level table base address |
| cfg_chk_unalloc | input | 1 | Enable the uncovered-bit misinsertion check |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Block idle, header accepted this cycle if valid |
| hdr_pv | input | 16 | Combined port and path field |
| hdr_vci | input | 16 | Channel field |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data strobe |
| rd_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result pulse |
| res_addr | output | 32 | Channel entry byte address |
| res_misins | output | 1 | Cell flagged as misinserted |

## Verification
Assertions watch the protocol on every cycle:
- a pending read request holding its address;
- a single request per cell;
- refusal of headers while busy;
- the result lasting exactly one cycle and arriving two cycles after a response;
- a zero address on misinserted results;
- packed pointers having no bits above the mask's set-bit count.

Only the bench scenarios can show the actual arithmetic values: the pointer order, the two-level address sums with wrap-around, the offset taken from the low half of the returned word, the misinsertion rule with the check on and off, configuration being sampled at acceptance, and stray responses being ignored.

// File: rtl/lkp_pkg.sv
package lkp_pkg;
  parameter int unsigned HDR_W  = 16;
  parameter int unsigned ADDR_W = 32;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned OFF_W  = 16;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_VP_READ = 3'd1,
    S_WAIT_VP = 3'd2,
    S_CALC_VC = 3'd3,
    S_DONE    = 3'd4
  } lkp_state_e;
endpackage

// File: rtl/lkp_rst_sync.sv
module lkp_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lkp_bit_gather.sv
module lkp_bit_gather #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] field,
  input  logic [W-1:0] mask,
  output logic [W-1:0] packed_ptr
);
  localparam int unsigned CW = $clog2(W) + 1;

  logic [CW-1:0] slot;

  always_comb begin
    packed_ptr = '0;
    slot       = '0;
    for (int i = 0; i < W; i++) begin
      packed_ptr = packed_ptr | (W'(field[i] & mask[i]) << slot);
      slot       = slot + CW'(mask[i]);
    end
  end

  always_comb begin
    AST_GATHER_DENSE: assert ((CW'($countones(packed_ptr)) <= CW'($countones(mask))) &&
                              ((packed_ptr >> $countones(mask)) == '0)); // R1
  end
endmodule

// File: rtl/lkp_ctrl.sv
module lkp_ctrl
  import lkp_pkg::*;
#(
  parameter int unsigned HW = 16,
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32,
  parameter int unsigned OW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_vp_mask,
  input  logic [HW-1:0] cfg_vc_mask,
  input  logic [AW-1:0] cfg_vp_base,
  input  logic [AW-1:0] cfg_vc_base,
  input  logic          cfg_chk_unalloc,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [HW-1:0] hdr_pv,
  input  logic [HW-1:0] hdr_vci,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          res_valid,
  output logic [AW-1:0] res_addr,
  output logic          res_misins,
  output logic [HW-1:0] q_pv,
  output logic [HW-1:0] q_vpm,
  output logic [HW-1:0] q_vci,
  output logic [HW-1:0] q_vcm,
  input  logic [HW-1:0] vp_ptr,
  input  logic [HW-1:0] vc_ptr
);
  localparam int unsigned WORD_SH = 2;

  lkp_state_e    state_q, state_d;
  logic [AW-1:0] vpb_q, vcb_q, addr_q, addr_d;
  logic [OW-1:0] off_q;
  logic          mis_q;

  logic          accept, unalloc_hit;
  logic          cap_en, off_en, addr_en, mis_en;
  logic [AW-1:0] vp_addr, vc_addr;

  assign accept      = hdr_valid && (state_q == S_IDLE);
  assign unalloc_hit = cfg_chk_unalloc && ((hdr_vci & ~cfg_vc_mask) != '0);

  assign cap_en  = accept;
  assign mis_en  = accept;
  assign off_en  = (state_q == S_WAIT_VP) && rd_rsp_valid;
  assign addr_en = (state_q == S_CALC_VC) || (accept && unalloc_hit);

  assign vp_addr = vpb_q + (AW'(vp_ptr) << WORD_SH);
  assign vc_addr = vcb_q + (AW'(off_q) << WORD_SH) + (AW'(vc_ptr) << WORD_SH);
  assign addr_d  = (state_q == S_CALC_VC) ? vc_addr : '0;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:    if (accept) state_d = unalloc_hit ? S_DONE : S_VP_READ;
      S_VP_READ: if (rd_req_ready) state_d = S_WAIT_VP;
      S_WAIT_VP: if (rd_rsp_valid) state_d = S_CALC_VC;
      S_CALC_VC: state_d = S_DONE;
      S_DONE:    state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      q_pv  <= hdr_pv;
      q_vci <= hdr_vci;
      q_vpm <= cfg_vp_mask;
      q_vcm <= cfg_vc_mask;
      vpb_q <= cfg_vp_base;
      vcb_q <= cfg_vc_base;
    end
  end

  always_ff @(posedge clk) begin
    if (mis_en) mis_q <= unalloc_hit;
  end

  always_ff @(posedge clk) begin
    if (off_en) off_q <= rd_rsp_data[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (addr_en) addr_q <= addr_d;
  end

  assign hdr_ready    = (state_q == S_IDLE);
  assign rd_req_valid = (state_q == S_VP_READ);
  assign rd_req_addr  = vp_addr;
  assign res_valid    = (state_q == S_DONE);
  assign res_addr     = addr_q;
  assign res_misins   = (state_q == S_DONE) && mis_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R2
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> !rd_req_valid); // R3
  AST_BUSY_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready |=> !hdr_ready); // R3
  AST_MIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_misins |-> res_addr == '0); // R6
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid); // R8
  AST_RES_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT_VP) && rd_rsp_valid |-> ##2 res_valid); // R8
endmodule

// File: rtl/conn_addr_lookup.sv
module conn_addr_lookup
  import lkp_pkg::*;
#(
  parameter int unsigned HW = lkp_pkg::HDR_W,
  parameter int unsigned AW = lkp_pkg::ADDR_W,
  parameter int unsigned DW = lkp_pkg::DATA_W,
  parameter int unsigned OW = lkp_pkg::OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] cfg_vp_mask,
  input  logic [HW-1:0] cfg_vc_mask,
  input  logic [AW-1:0] cfg_vp_base,
  input  logic [AW-1:0] cfg_vc_base,
  input  logic          cfg_chk_unalloc,
  input  logic          hdr_valid,
  output logic          hdr_ready,
  input  logic [HW-1:0] hdr_pv,
  input  logic [HW-1:0] hdr_vci,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          res_valid,
  output logic [AW-1:0] res_addr,
  output logic          res_misins
);
  localparam int unsigned N_LEVELS = 2;

  logic                rst_n_s;
  logic [HW-1:0]       q_pv, q_vpm, q_vci, q_vcm;
  logic [N_LEVELS-1:0][HW-1:0] lvl_field, lvl_mask, lvl_ptr;

  lkp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign lvl_field[0] = q_pv;
  assign lvl_mask[0]  = q_vpm;
  assign lvl_field[1] = q_vci;
  assign lvl_mask[1]  = q_vcm;

  for (genvar g = 0; g < N_LEVELS; g++) begin : g_level
    lkp_bit_gather #(.W(HW)) u_gather (
      .field      (lvl_field[g]),
      .mask       (lvl_mask[g]),
      .packed_ptr (lvl_ptr[g])
    );
  end

  lkp_ctrl #(.HW(HW), .AW(AW), .DW(DW), .OW(OW)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n_s),
    .cfg_vp_mask     (cfg_vp_mask),
    .cfg_vc_mask     (cfg_vc_mask),
    .cfg_vp_base     (cfg_vp_base),
    .cfg_vc_base     (cfg_vc_base),
    .cfg_chk_unalloc (cfg_chk_unalloc),
    .hdr_valid       (hdr_valid),
    .hdr_ready       (hdr_ready),
    .hdr_pv          (hdr_pv),
    .hdr_vci         (hdr_vci),
    .rd_req_valid    (rd_req_valid),
    .rd_req_ready    (rd_req_ready),
    .rd_req_addr     (rd_req_addr),
    .rd_rsp_valid    (rd_rsp_valid),
    .rd_rsp_data     (rd_rsp_data),
    .res_valid       (res_valid),
    .res_addr        (res_addr),
    .res_misins      (res_misins),
    .q_pv            (q_pv),
    .q_vpm           (q_vpm),
    .q_vci           (q_vci),
    .q_vcm           (q_vcm),
    .vp_ptr          (lvl_ptr[0]),
    .vc_ptr          (lvl_ptr[1])
  );
endmodule

// File: tb/conn_addr_lookup_tb.sv
module conn_addr_lookup_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_vp_mask = '0, cfg_vc_mask = '0;
  logic [31:0] cfg_vp_base = '0, cfg_vc_base = '0;
  logic        cfg_chk_unalloc = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [15:0] hdr_pv = '0, hdr_vci = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [31:0] rd_req_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic        res_valid;
  logic [31:0] res_addr;
  logic        res_misins;

  int n_chk  = 0;
  int n_fail = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  conn_addr_lookup u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_vp_mask(cfg_vp_mask), .cfg_vc_mask(cfg_vc_mask),
    .cfg_vp_base(cfg_vp_base), .cfg_vc_base(cfg_vc_base),
    .cfg_chk_unalloc(cfg_chk_unalloc),
    .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_pv(hdr_pv), .hdr_vci(hdr_vci),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .res_valid(res_valid), .res_addr(res_addr), .res_misins(res_misins)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pack_bits(input logic [15:0] v, input logic [15:0] m);
    int k = 0;
    pack_bits = '0;
    for (int i = 0; i < 16; i++) begin
      if (m[i]) begin
        pack_bits[k] = v[i];
        k++;
      end
    end
  endfunction

  task automatic scramble_cfg();
    cfg_vp_mask     = 16'($urandom);
    cfg_vc_mask     = 16'($urandom);
    cfg_vp_base     = $urandom;
    cfg_vc_base     = $urandom;
    cfg_chk_unalloc = 1'($urandom);
    hdr_pv          = 16'($urandom);
    hdr_vci         = 16'($urandom);
  endtask

  task automatic run_cell(input logic [15:0] pv, input logic [15:0] vci,
                          input logic [15:0] vpm, input logic [15:0] vcm,
                          input logic [31:0] vpb, input logic [31:0] vcb,
                          input logic chk, input logic [31:0] rsp,
                          input int rdy_dly, input int rsp_dly, input string tag);
    logic        mis;
    logic [31:0] exp_vp, exp_vc;
    mis    = chk && ((vci & ~vcm) != 16'h0);
    exp_vp = vpb + {14'b0, pack_bits(pv, vpm), 2'b00};
    exp_vc = vcb + {14'b0, rsp[15:0], 2'b00} + {14'b0, pack_bits(vci, vcm), 2'b00};
    @(negedge clk);
    check({"R3 idle ready ", tag}, 32'(hdr_ready), 32'd1);
    cfg_vp_mask = vpm; cfg_vc_mask = vcm; cfg_vp_base = vpb; cfg_vc_base = vcb;
    cfg_chk_unalloc = chk; hdr_pv = pv; hdr_vci = vci; hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    scramble_cfg();  // R9: changes after acceptance
    if (mis) begin
      check({"R6 result at once ", tag}, 32'(res_valid), 32'd1);
      check({"R6 flag ", tag}, 32'(res_misins), 32'd1);
      check({"R6 zero addr ", tag}, res_addr, 32'd0);
      check({"R6 no read ", tag}, 32'(rd_req_valid), 32'd0);
      @(negedge clk);
      check({"R8 pulse ", tag}, 32'(res_valid), 32'd0);
      check({"R6 no read after ", tag}, 32'(rd_req_valid), 32'd0);
      return;
    end
    check({"R2 req valid ", tag}, 32'(rd_req_valid), 32'd1);
    check({"R2 R9 req addr ", tag}, rd_req_addr, exp_vp);
    check({"R3 busy ", tag}, 32'(hdr_ready), 32'd0);
    for (int i = 0; i < rdy_dly; i++) begin
      @(negedge clk);
      check({"R2 hold valid ", tag}, 32'(rd_req_valid), 32'd1);
      check({"R2 hold addr ", tag}, rd_req_addr, exp_vp);
    end
    rd_req_ready = 1'b1;
    @(negedge clk);
    rd_req_ready = 1'b0;
    check({"R3 single read ", tag}, 32'(rd_req_valid), 32'd0);
    for (int i = 0; i < rsp_dly; i++) begin
      @(negedge clk);
      check({"R3 no extra read ", tag}, 32'(rd_req_valid), 32'd0);
      check({"R8 no early result ", tag}, 32'(res_valid), 32'd0);
    end
    rd_rsp_valid = 1'b1;
    rd_rsp_data  = rsp;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    rd_rsp_data  = $urandom;
    check({"R8 not yet ", tag}, 32'(res_valid), 32'd0);
    @(negedge clk);
    check({"R8 result pulse ", tag}, 32'(res_valid), 32'd1);
    check({"R4 R5 R9 address ", tag}, res_addr, exp_vc);
    check({"R7 flag clear ", tag}, 32'(res_misins), 32'd0);
    @(negedge clk);
    check({"R8 single cycle ", tag}, 32'(res_valid), 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R10 reset state
    check("R10 hdr_ready", 32'(hdr_ready), 32'd1);
    check("R10 rd_req_valid", 32'(rd_req_valid), 32'd0);
    check("R10 res_valid", 32'(res_valid), 32'd0);

    // R1 R2 R5 worked example
    run_cell(16'h0011, 16'h0031, 16'h0237, 16'h0037, 32'h0024_0000, 32'h0084_0000,
             1'b1, 32'h0000_0100, 0, 0, "R1 example");
    // R4 upper half of response ignored
    run_cell(16'h0011, 16'h0031, 16'h0237, 16'h0037, 32'h0024_0000, 32'h0084_0000,
             1'b0, 32'hDEAD_0100, 2, 3, "R4 upper");
    // R1 full ten-bit channel mask, 1024 entries
    run_cell(16'hFFFF, 16'h03FF, 16'hFFFF, 16'h03FF, 32'h0000_1000, 32'h0010_0000,
             1'b1, 32'h0000_0000, 1, 1, "R1 full mask");
    // R1 empty masks give pointer zero
    run_cell(16'hABCD, 16'h1234, 16'h0000, 16'h0000, 32'h0000_0040, 32'h0000_0080,
             1'b0, 32'h0000_0001, 0, 0, "R1 empty mask");
    // R5 wrap-around
    run_cell(16'h8001, 16'h8000, 16'h8001, 16'h8000, 32'hFFFF_FFF0, 32'hFFFF_FFF8,
             1'b1, 32'h0000_FFFF, 0, 2, "R5 wrap");
    // R6 misinserted
    run_cell(16'h0011, 16'h0431, 16'h0237, 16'h0037, 32'h0024_0000, 32'h0084_0000,
             1'b1, 32'h0, 0, 0, "R6 mis");
    // R7 same header, check disabled
    run_cell(16'h0011, 16'h0431, 16'h0237, 16'h0037, 32'h0024_0000, 32'h0084_0000,
             1'b0, 32'h0000_0100, 0, 0, "R7 nochk");

    // R11 stray response while idle
    @(negedge clk);
    rd_rsp_valid = 1'b1;
    rd_rsp_data  = 32'h0000_0777;
    @(negedge clk);
    rd_rsp_valid = 1'b0;
    check("R11 no result", 32'(res_valid), 32'd0);
    check("R11 still idle", 32'(hdr_ready), 32'd1);
    @(negedge clk);
    check("R11 no late result", 32'(res_valid), 32'd0);
    check("R11 no read", 32'(rd_req_valid), 32'd0);
    run_cell(16'h0011, 16'h0031, 16'h0237, 16'h0037, 32'h0024_0000, 32'h0084_0000,
             1'b1, 32'h0000_0100, 0, 0, "R11 after stray");

    // random mix
    for (int n = 0; n < 60; n++) begin
      logic [15:0] vcm, vci;
      vcm = 16'($urandom);
      vci = 16'($urandom);
      if ($urandom_range(0, 1) == 0) vci = vci & vcm;
      run_cell(16'($urandom), vci, 16'($urandom), vcm, $urandom, $urandom,
               1'($urandom), $urandom, $urandom_range(0, 3), $urandom_range(0, 4),
               "R1 R5 R6 random");
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule